// File: doc/BRIEF.md
# DDS Sine PWM Tone Generator

This block produces an audio-band sine tone on a single digital pin as a pulse-width-modulated waveform, using direct digital synthesis. A free-running 8-bit counter defines a 256-cycle PWM frame. When the counter wraps, a 16-bit phase accumulator advances by a selected increment. The accumulator's upper byte addresses a computed 256-entry sine table, and the value read becomes the duty cycle of a later frame. An external low-pass filter, which is not part of this block, turns the pin into an analog tone.

The tone is chosen by an 8-bit control word, typically the digitised position of a knob. Its top three bits pick one increment from a geometric set of seven, and codes beyond the last set entry are clamped to it. Each wrap also produces a one-cycle strobe that marks the first cycle of a new frame. While the enable input is low, the block is parked: the counter is held at zero, the phase does not move and the pin stays low.

Top module: `tone_synth`

## Requirements
- R1: After reset, pwm_o and strobe_o are low, and the phase, the increment and the duty are 0, 0 and 0x80. The first complete frame after enabling is therefore high for exactly 128 cycles.
- R2: While enabled, a frame lasts exactly 256 clock cycles. strobe_o is high for one cycle in the first cycle of every frame and low in all other cycles.
- R3: Within a frame, pwm_o is high in the first D cycles and low in the remaining 256-D cycles, where D is that frame's duty. A duty of 0 keeps the pin low for the whole frame, and a duty of 255 keeps it high for 255 cycles.
- R4: Sine table entry i (0..255) equals floor(127.5 + 127.5*sin(2*pi*i/256) + 0.5). Entry 0 is 0x80, entry 64 is 0xFF and entry 192 is 0x00.
- R5: The 16-bit phase adds the current increment once per wrap, modulo 65536. The table is addressed by phase bits 15..8.
- R6: The increment loaded at a wrap is 2 << (2*k), where k = freq_i >> 5, clamped to 6. This gives the set 2, 8, 32, 128, 512, 2048 and 8192.
- R7: freq_i is sampled only at the clock edge where the counter wraps. It is used for the phase addition at the following wrap, and values present at any other time have no effect.
- R8: The duty of the frame that starts at wrap k is the table entry addressed by the phase as it stood before wrap k. This is the value produced at wrap k-1.
- R9: While en_i is low, the counter is held at zero, pwm_o and strobe_o are low, and the phase and the increment keep their values. Counting resumes from zero when en_i returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low parks the generator |
| freq_i | input | 8 | Tone control word; the top three bits select the increment |
| pwm_o | output | 1 | Registered PWM output |
| strobe_o | output | 1 | One-cycle marker of the first cycle of each frame |

## Verification
The hardest situation to reach is a change on freq_i that is not seen until a later wrap. The control word may change, even several times, in the middle of a frame, and only its value at the wrap edge counts. That value then shows up in the measured duty two frames later. To reach this, the stimulus changes the word at a random point inside a frame, sometimes after a short-lived glitch value. It parks the block for random stretches and checks that the phase resumes where it stopped. It also runs the largest increment for whole cycles of the wave, so that frames with duty 0 and duty 255 both occur.

// File: rtl/tone_pkg.sv
package tone_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Rounded sine sample centred on midscale, spanning 0 .. 2**dw-1
  function automatic int sine_code(input int idx, input int aw, input int dw);
    real amp;
    real ang;
    amp = ((2.0 ** dw) - 1.0) / 2.0;
    ang = TWO_PI * idx / (2.0 ** aw);
    return $rtoi(amp + amp * $sin(ang) + 0.5);
  endfunction

  // Geometric increment set: base, base<<shift, base<<2*shift, ...
  function automatic longint step_inc(input int k, input int base, input int shift);
    return longint'(base) << (shift * k);
  endfunction

endpackage

// File: rtl/tone_pwm_counter.sv
module tone_pwm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assign wrap_o  = en_i && (cnt_q == TOP);
  assign cnt_nxt = en_i ? cnt_q + 1'b1 : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_nxt;
  end

  // R9: parked counter sits at zero
  p_park_zero_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (cnt_q == '0));

  // R2: single-slope count, one step per cycle and wrap to zero
  p_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/tone_phase_accum.sv
module tone_phase_accum #(
  parameter int ACC_W      = 16,
  parameter int FREQ_W     = 8,
  parameter int SEL_W      = 3,
  parameter int NUM_STEPS  = 7,
  parameter int BASE_INC   = 2,
  parameter int STEP_SHIFT = 2,
  parameter int LUT_AW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wrap_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic [LUT_AW-1:0] addr_o
);
  import tone_pkg::*;

  localparam int LAST = NUM_STEPS - 1;

  logic [ACC_W-1:0] inc_tab [NUM_STEPS];
  logic [ACC_W-1:0] phase_q;
  logic [ACC_W-1:0] inc_q;
  logic [SEL_W-1:0] sel;
  logic [SEL_W-1:0] idx;
  logic             unused_low;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_inc
    assign inc_tab[g] = ACC_W'(step_inc(g, BASE_INC, STEP_SHIFT));
  end

  assign sel        = freq_i[FREQ_W-1 -: SEL_W];
  assign unused_low = ^freq_i[FREQ_W-SEL_W-1:0];

  always_comb begin
    if (int'(sel) > LAST) idx = SEL_W'(LAST);
    else                  idx = sel;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= '0;
      inc_q   <= '0;
    end else if (wrap_i) begin
      phase_q <= phase_q + inc_q;
      inc_q   <= inc_tab[idx];
    end
  end

  assign addr_o = phase_q[ACC_W-1 -: LUT_AW];

  // R7 / R9: between wraps (and while parked) nothing moves
  p_hold_between_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !wrap_i |=> ($stable(phase_q) && $stable(inc_q)));

  // R6: every increment in the set is a single power of two (or zero after reset)
  p_inc_pow2_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_i |=> ($countones(inc_q) <= 1));
endmodule

// File: rtl/tone_sine_rom.sv
module tone_sine_rom #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_q
);
  import tone_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(sine_code(i, AW, DW));
  end

  always_ff @(posedge clk_i) data_q <= mem[addr_i];
endmodule

// File: rtl/tone_synth.sv
module tone_synth #(
  parameter int ACC_W      = 16,
  parameter int CNT_W      = 8,
  parameter int FREQ_W     = 8,
  parameter int SEL_W      = 3,
  parameter int NUM_STEPS  = 7,
  parameter int BASE_INC   = 2,
  parameter int STEP_SHIFT = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic              pwm_o,
  output logic              strobe_o
);
  localparam int LUT_AW = CNT_W;
  localparam int DUTY_W = CNT_W;
  localparam logic [DUTY_W-1:0] MID = DUTY_W'(1) << (DUTY_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              wrap;
  logic [LUT_AW-1:0] addr;
  logic [DUTY_W-1:0] sine_q;
  logic [DUTY_W-1:0] duty_q;
  logic [DUTY_W-1:0] duty_nxt;

  tone_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .wrap_o(wrap)
  );

  tone_phase_accum #(
    .ACC_W(ACC_W), .FREQ_W(FREQ_W), .SEL_W(SEL_W), .NUM_STEPS(NUM_STEPS),
    .BASE_INC(BASE_INC), .STEP_SHIFT(STEP_SHIFT), .LUT_AW(LUT_AW)
  ) u_acc (
    .clk_i(clk_i), .rst_i(rst_i), .wrap_i(wrap), .freq_i(freq_i), .addr_o(addr)
  );

  tone_sine_rom #(.AW(LUT_AW), .DW(DUTY_W)) u_rom (
    .clk_i(clk_i), .addr_i(addr), .data_q(sine_q)
  );

  // Duty is reloaded only at wrap, from the sample read for the phase before it
  assign duty_nxt = wrap ? sine_q : duty_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      duty_q   <= MID;
      pwm_o    <= 1'b0;
      strobe_o <= 1'b0;
    end else begin
      duty_q   <= duty_nxt;
      pwm_o    <= en_i && (cnt_nxt < duty_nxt);
      strobe_o <= wrap;
    end
  end

  // R2: strobe never lasts two cycles
  p_strobe_single_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_o |=> !strobe_o);

  // R9: parked outputs are low
  p_park_low_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (!pwm_o && !strobe_o));

  // R3: zero duty never drives the pin high
  p_zero_duty_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (duty_q == '0) |-> !pwm_o);

  // R3: the pin is high in the first cycle of a frame unless the duty is zero
  p_frame_start_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (strobe_o && duty_q != '0) |-> pwm_o);
endmodule

// File: tb/tone_synth_bench.sv
module tone_synth_bench;
  logic       clk = 1'b0;
  logic       rst_i;
  logic       en_i;
  logic [7:0] freq_i;
  logic       pwm_o;
  logic       strobe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tone_synth u_tone_synth (
    .clk_i(clk), .rst_i(rst_i), .en_i(en_i), .freq_i(freq_i),
    .pwm_o(pwm_o), .strobe_o(strobe_o)
  );

  function automatic int exp_sine(input int i);
    real a;
    a = 127.5 + 127.5 * $sin(6.283185307179586 * i / 256.0);
    return $rtoi(a + 0.5);
  endfunction

  function automatic logic [15:0] exp_inc(input logic [7:0] f);
    int k;
    k = int'(f >> 5);
    if (k > 6) k = 6;
    return 16'(2 << (2 * k));
  endfunction

  // Monitor state
  int          len = 0;
  int          hi = 0;
  int          nper = 0;
  int          duty_m = 128;
  bit          valid = 1'b0;
  bit          en_d = 1'b0;
  logic [15:0] ph_m = '0;
  logic [15:0] inc_m = '0;

  always @(negedge clk) begin
    if (rst_i) begin
      en_d = 1'b0; valid = 1'b0; ph_m = '0; inc_m = '0; duty_m = 128; nper = 0;
    end else if (!done) begin
      if (!en_d) begin
        checks++;
        if (pwm_o || strobe_o) begin
          fails++;
          $display("FAIL R9 parked outputs pwm=%0b strobe=%0b expected 0 0", pwm_o, strobe_o);
        end
        valid = 1'b0;
      end else if (strobe_o) begin
        if (valid) begin
          checks++;
          if (len != 256) begin
            fails++;
            $display("FAIL R2 frame length %0d expected 256", len);
          end
          checks++;
          if (hi != duty_m) begin
            fails++;
            $display("FAIL R3 R4 R5 R6 R7 R8 high cycles %0d expected %0d (frame %0d)", hi, duty_m, nper);
          end
          if (nper == 1) begin
            checks++;
            if (hi != 128) begin
              fails++;
              $display("FAIL R1 first frame high cycles %0d expected 128", hi);
            end
          end
        end
        duty_m = exp_sine(int'(ph_m[15:8]));
        ph_m   = ph_m + inc_m;
        inc_m  = exp_inc(freq_i);
        nper++;
        valid = 1'b1;
        len   = 1;
        hi    = int'(pwm_o);
      end else begin
        len++;
        hi += int'(pwm_o);
        if (valid && len > 256) begin
          checks++; fails++;
          $display("FAIL R2 no strobe after %0d cycles expected 256", len);
          valid = 1'b0;
        end
      end
      en_d = en_i;
    end
  end

  task automatic wait_strobe();
    do @(negedge clk); while (!strobe_o);
  endtask

  // One frame of stimulus: mid-frame word change, optional glitch, optional park
  task automatic frame_step(input logic [7:0] f, input bit glitch, input logic [7:0] gval,
                            input bit park, input int park_len);
    int pos;
    wait_strobe();
    pos = 20 + int'($urandom % 100);
    repeat (pos) @(posedge clk);
    #1;
    if (glitch) begin
      freq_i = gval;          // R7: must be ignored, replaced before the wrap
      repeat (3) @(posedge clk);
      #1;
    end
    freq_i = f;
    if (park) begin
      en_i = 1'b0;
      repeat (park_len) @(posedge clk);
      #1;
      en_i = 1'b1;
    end
  endtask

  initial begin
    void'($urandom(32'd90817));
    rst_i = 1'b1; en_i = 1'b0; freq_i = 8'hFF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pwm_o || strobe_o) begin
      fails++;
      $display("FAIL R1 reset outputs pwm=%0b strobe=%0b expected 0 0", pwm_o, strobe_o);
    end
    @(posedge clk); #1;
    rst_i = 1'b0;
    repeat (6) @(posedge clk); #1;
    en_i = 1'b1;
    // Largest step (code 7 clamps to 6): whole sine cycles, duty 0 and 255 frames
    for (int i = 0; i < 20; i++) frame_step(8'hFF, 1'b0, 8'h00, 1'b0, 0);
    for (int i = 0; i < 4; i++)  frame_step(8'hC0, 1'b0, 8'h00, 1'b0, 0);
    for (int i = 0; i < 4; i++)  frame_step(8'h1F, 1'b0, 8'h00, 1'b0, 0);
    for (int i = 0; i < 4; i++)  frame_step(8'hE0, 1'b0, 8'h00, 1'b0, 0);
    for (int i = 0; i < 4; i++)  frame_step(8'h40, 1'b1, 8'hFF, 1'b0, 0);
    frame_step(8'hA5, 1'b0, 8'h00, 1'b1, 40);
    frame_step(8'hA5, 1'b0, 8'h00, 1'b1, 1);
    for (int i = 0; i < 200; i++) begin
      logic [7:0] f;
      logic [7:0] g;
      bit         gl;
      bit         pk;
      f  = 8'($urandom);
      g  = 8'($urandom);
      gl = ($urandom % 4) == 0;
      pk = ($urandom % 10) == 0;
      frame_step(f, gl, g, pk, 1 + int'($urandom % 60));
    end
    wait_strobe();
    wait_strobe();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired, stimulus did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule